// File: doc/BRIEF.md
# Multi-Channel Receive FIFO Collector

This block gathers 24-bit sample words from up to four serial receiver channels into one shared 128-entry FIFO. A host drains that FIFO through a read port that returns 32-bit words. Each receiver offers words on its own valid/ready pair. The collector takes words strictly in turn: it serves the enabled channels in ascending order and wraps around after the last one. A channel whose turn has not come is held off because its ready stays low. Each word is stored together with the index of the channel it came from. The host can therefore see which channel produced the word at the head of the FIFO, and which channel must supply the next word.

The word is placed into the 32-bit host word when it is read. A 3-bit alignment code k puts the data MSB at host bit 31-4k. A sign control fills the bits above the MSB either with zeros or with copies of the MSB.

Back-pressure works as follows. On the receive side, a transfer takes place on a clock edge where both `rx_valid[c]` and `rx_ready[c]` are high. At most one ready bit is high at any time. A receiver may hold its valid high for as long as it likes. A word accepted while the FIFO is full is dropped, and the sticky overflow flag is set. On the host side, `host_valid` is high whenever the FIFO holds a word, and a pop happens on an edge where both `host_valid` and `host_ready` are high. The status pins are plain levels: a flush bit, a watermark, an occupancy count and a data-available flag.

Top module: `rx_fifo_collector`

## Requirements
- R1: After reset the FIFO is empty, `fill_level` is 0, `overflow` is 0, `host_valid` is 0 and `next_push_chan` is 0 when channel 0 is enabled.
- R2: `next_push_chan` names the first enabled channel found by searching upward, with wraparound, from a turn pointer. Only that channel sees `rx_ready` high. After each accepted word the pointer moves to the channel above the one that was served, wrapping from 3 to 0.
- R3: A channel whose enable bit is 0 never sees `rx_ready` high. If no channel is enabled, all ready bits are 0.
- R4: While `cfg_enable` is 0, all `rx_ready` bits are 0 and nothing is written into the FIFO. Popping still works.
- R5: Words leave in arrival order. `next_pop_chan` gives the source channel of the head word. When the FIFO is empty it equals `next_push_chan`.
- R6: With alignment code k, the 24-bit word w appears as host_data = {w, 8'b0} shifted right by 4k. Code 0 puts w in bits 31..8, code 2 puts it in bits 23..0, and codes 3 to 7 drop the low 4(k-2) bits of w.
- R7: With `cfg_sign_ext` at 1, the host bits above the data MSB copy w[23]. With it at 0, they are zero.
- R8: `fill_level` equals the number of stored words, 0 to 128. `data_avail` is 1 exactly when `fill_level` >= `cfg_watermark`.
- R9: A word accepted while 128 words are stored is discarded and sets `overflow`. The flag stays set until a flush or a reset.
- R10: While the FIFO is empty, `host_data` is 0 and a pop request changes nothing.
- R11: While `cfg_flush` is 1, no ready bit is high. On the next edge the FIFO is emptied, the count and `overflow` are cleared, and the turn pointer returns to 0.
- R12: Alignment and sign settings act on the word at read time. Changing them changes `host_data` for a word that is already stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_enable | input | 1 | Collector enable |
| cfg_flush | input | 1 | Empty FIFO, clear count and overflow, reset turn |
| cfg_chan_en | input | 4 | Per-channel participation enables |
| cfg_watermark | input | 8 | Data-available threshold |
| cfg_align | input | 3 | Alignment code k, MSB at bit 31-4k |
| cfg_sign_ext | input | 1 | 1 = sign fill, 0 = zero fill |
| rx_valid | input | 4 | Per-channel word offered |
| rx_data | input | 96 | Channel c word in bits 24c+23..24c |
| rx_ready | output | 4 | Per-channel accept, at most one high |
| host_valid | output | 1 | FIFO not empty |
| host_ready | input | 1 | Host pops the head word |
| host_data | output | 32 | Aligned head word, 0 when empty |
| fill_level | output | 8 | Stored word count |
| data_avail | output | 1 | fill_level >= cfg_watermark |
| overflow | output | 1 | Sticky dropped-word flag |
| next_push_chan | output | 2 | Channel that must supply the next word |
| next_pop_chan | output | 2 | Source channel of the next popped word |

## Verification
A corrupted turn pointer shows up at once on `rx_ready` and `next_push_chan`, in the same cycle, because both are decoded from the pointer combinationally. A bad read or write pointer, or a bad count, shows up on `host_data`, `next_pop_chan` or `fill_level` in the cycle after the faulty edge. A wrong count also shows on `data_avail` wherever the watermark lies between the true and the corrupted value. An error in the alignment or extension path is visible on the very next head word, for any code under which the differing bits are not masked away.

// File: rtl/rxc_pkg.sv
package rxc_pkg;
  localparam int WORD_W = 24;
  localparam int HOST_W = 32;
  localparam int PAD_W  = HOST_W - WORD_W;

  // Place the word with its MSB at bit HOST_W-1-4*code, filling above
  function automatic logic [HOST_W-1:0] realign(input logic [WORD_W-1:0] w,
                                                input logic [2:0] code,
                                                input logic sext);
    logic signed [HOST_W-1:0] t;
    t = $signed({w, {PAD_W{1'b0}}});
    if (sext) return HOST_W'(t >>> (4 * int'(code)));
    else      return HOST_W'($unsigned(t) >> (4 * int'(code)));
  endfunction
endpackage

// File: rtl/rxc_rr_pick.sv
module rxc_rr_pick #(
  parameter int NCH = 4,
  localparam int IW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           flush,
  input  logic           enable,
  input  logic [NCH-1:0] chan_en,
  input  logic [NCH-1:0] in_valid,
  output logic [NCH-1:0] in_ready,
  output logic           take,
  output logic [IW-1:0]  sel
);
  logic [IW-1:0] turn;
  logic          found;

  always_comb begin
    found = 1'b0;
    sel   = turn;
    for (int i = 0; i < NCH; i++) begin
      int c;
      c = (int'(turn) + i) % NCH;
      if (!found && chan_en[c]) begin
        found = 1'b1;
        sel   = IW'(c);
      end
    end
  end

  assign in_ready = (enable && !flush && found) ? (NCH'(1) << sel) : '0;
  assign take     = |(in_valid & in_ready);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     turn <= '0;
    else if (flush) turn <= '0;
    else if (take)  turn <= (int'(sel) == NCH - 1) ? '0 : sel + IW'(1);
  end

  // R3
  ready_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready & ~chan_en) == '0);
  // R2
  ready_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(in_ready));
  // R4
  ready_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> !take);
endmodule

// File: rtl/rxc_store.sv
module rxc_store #(
  parameter int DEPTH = 128,
  parameter int EW    = 26,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          wr,
  input  logic [EW-1:0] wdata,
  input  logic          rd,
  output logic [EW-1:0] head,
  output logic [CW-1:0] count,
  output logic          empty,
  output logic          full,
  output logic          ovf
);
  logic [EW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          push_ok, pop_ok;

  assign empty   = (count == '0);
  assign full    = (count == CW'(DEPTH));
  assign push_ok = wr && !full && !flush;
  assign pop_ok  = rd && !empty && !flush;
  assign head    = mem[rp];

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (int'(p) == DEPTH - 1) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (push_ok) mem[wp] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; count <= '0; ovf <= 1'b0;
    end else if (flush) begin
      wp <= '0; rp <= '0; count <= '0; ovf <= 1'b0;
    end else begin
      if (push_ok) wp <= bump(wp);
      if (pop_ok)  rp <= bump(rp);
      if (push_ok && !pop_ok)      count <= count + CW'(1);
      else if (pop_ok && !push_ok) count <= count - CW'(1);
      if (wr && full) ovf <= 1'b1;
    end
  end

  // R11
  flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (count == '0) && !ovf);
  // R9
  ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && full && !flush) |=> ovf);
  // R8
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  // R10
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && !wr && !flush) |=> empty);
endmodule

// File: rtl/rx_fifo_collector.sv
module rx_fifo_collector import rxc_pkg::*; #(
  parameter int NCH   = 4,
  parameter int DEPTH = 128,
  localparam int IW   = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_enable,
  input  logic                  cfg_flush,
  input  logic [NCH-1:0]        cfg_chan_en,
  input  logic [CW-1:0]         cfg_watermark,
  input  logic [2:0]            cfg_align,
  input  logic                  cfg_sign_ext,
  input  logic [NCH-1:0]        rx_valid,
  input  logic [NCH*WORD_W-1:0] rx_data,
  output logic [NCH-1:0]        rx_ready,
  output logic                  host_valid,
  input  logic                  host_ready,
  output logic [HOST_W-1:0]     host_data,
  output logic [CW-1:0]         fill_level,
  output logic                  data_avail,
  output logic                  overflow,
  output logic [IW-1:0]         next_push_chan,
  output logic [IW-1:0]         next_pop_chan
);
  localparam int EW = IW + WORD_W;

  logic          take, empty, full;
  logic [IW-1:0] sel;
  logic [EW-1:0] wword, head;

  rxc_rr_pick #(.NCH(NCH)) u_pick (
    .clk(clk), .rst_n(rst_n), .flush(cfg_flush), .enable(cfg_enable),
    .chan_en(cfg_chan_en), .in_valid(rx_valid), .in_ready(rx_ready),
    .take(take), .sel(sel)
  );

  assign wword = {sel, rx_data[int'(sel)*WORD_W +: WORD_W]};

  rxc_store #(.DEPTH(DEPTH), .EW(EW)) u_store (
    .clk(clk), .rst_n(rst_n), .flush(cfg_flush), .wr(take), .wdata(wword),
    .rd(host_ready), .head(head), .count(fill_level), .empty(empty),
    .full(full), .ovf(overflow)
  );

  assign host_valid     = !empty;
  assign host_data      = empty ? '0 : realign(head[WORD_W-1:0], cfg_align, cfg_sign_ext);
  assign data_avail     = (fill_level >= cfg_watermark);
  assign next_push_chan = sel;
  assign next_pop_chan  = empty ? sel : head[EW-1 -: IW];

  // R5
  hold_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_valid && !host_ready && !cfg_flush) |=> host_valid);
  // R10
  empty_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_level == '0) |-> (host_data == '0));
endmodule

// File: tb/sim_rx_fifo_collector.sv
`timescale 1ns/1ps
module sim_rx_fifo_collector;
  logic        clk = 0, rst_n = 0;
  logic        cfg_enable = 0, cfg_flush = 0, cfg_sign_ext = 0;
  logic [3:0]  cfg_chan_en = 0;
  logic [7:0]  cfg_watermark = 0;
  logic [2:0]  cfg_align = 0;
  logic [3:0]  rx_valid = 0, rx_ready;
  logic [95:0] rx_data = 0;
  logic        host_valid, host_ready = 0, data_avail, overflow;
  logic [31:0] host_data;
  logic [7:0]  fill_level;
  logic [1:0]  next_push_chan, next_pop_chan;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [25:0] q[$];
  int  mptr = 0;
  bit  movf = 0;

  always #4 clk = ~clk;

  rx_fifo_collector u0 (.*);

  function automatic logic [31:0] align_ref(input logic [23:0] w, input int k, input logic sx);
    logic [31:0] r;
    for (int j = 0; j < 32; j++) begin
      int s;
      s = j + 4 * k - 8;
      if (s > 23)     r[j] = sx ? w[23] : 1'b0;
      else if (s < 0) r[j] = 1'b0;
      else            r[j] = w[s];
    end
    return r;
  endfunction

  task automatic pick(input int p, input logic [3:0] en, output bit f, output int e);
    f = 0; e = p;
    for (int i = 0; i < 4; i++) begin
      int c;
      c = (p + i) % 4;
      if (!f && en[c]) begin f = 1; e = c; end
    end
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input logic [3:0] v, input logic rdy, input logic fl);
    bit f; int e; logic [3:0] er; int pre; bit acc;
    @(negedge clk);
    rx_valid = v; host_ready = rdy; cfg_flush = fl;
    for (int c = 0; c < 4; c++) rx_data[c*24 +: 24] = 24'($urandom);
    #2;
    pick(mptr, cfg_chan_en, f, e);
    er = (cfg_enable && !fl && f) ? 4'(1 << e) : 4'b0;
    pre = q.size();
    chk("R2 rx_ready", 32'(rx_ready), 32'(er));
    chk("R2 next_push_chan", 32'(next_push_chan), 32'(e));
    chk("R5 host_valid", 32'(host_valid), 32'(pre > 0));
    chk("R5 next_pop_chan", 32'(next_pop_chan), pre > 0 ? 32'(q[0][25:24]) : 32'(e));
    chk("R6/R7 host_data", host_data,
        pre > 0 ? align_ref(q[0][23:0], int'(cfg_align), cfg_sign_ext) : 32'h0);
    chk("R8 fill_level", 32'(fill_level), 32'(pre));
    chk("R8 data_avail", 32'(data_avail), 32'(pre >= int'(cfg_watermark)));
    chk("R9 overflow", 32'(overflow), 32'(movf));
    if (fl) begin
      q.delete(); mptr = 0; movf = 0;
    end else begin
      acc = |(er & v);
      if (rdy && pre > 0) void'(q.pop_front());
      if (acc) begin
        if (pre >= 128) movf = 1;
        else q.push_back({2'(e), rx_data[e*24 +: 24]});
        mptr = (e + 1) % 4;
      end
    end
    @(posedge clk); #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7321));
    cfg_chan_en = 4'hF;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset state
    #1;
    chk("R1 fill_level", 32'(fill_level), 0);
    chk("R1 overflow", 32'(overflow), 0);
    chk("R1 host_valid", 32'(host_valid), 0);
    chk("R1 next_push_chan", 32'(next_push_chan), 0);
    step(4'h0, 0, 0);

    // R3: only channels 1 and 3 participate
    cfg_enable = 1; cfg_chan_en = 4'b1010;
    step(4'hF, 0, 0);
    chk("R3 ch0 held off", 32'(rx_ready[0] | rx_ready[2]), 0);
    for (int i = 0; i < 6; i++) step(4'hF, 0, 0);
    cfg_chan_en = 4'b0000;
    step(4'hF, 0, 0);
    chk("R3 none enabled", 32'(rx_ready), 0);

    // R4: disabled collector accepts nothing, still pops
    cfg_chan_en = 4'hF; cfg_enable = 0;
    for (int i = 0; i < 4; i++) step(4'hF, 1, 0);
    chk("R4 no ready when off", 32'(rx_ready), 0);

    // R11 flush
    cfg_enable = 1;
    for (int i = 0; i < 5; i++) step(4'hF, 0, 0);
    step(4'hF, 0, 1);
    chk("R11 level after flush", 32'(fill_level), 0);
    chk("R11 turn after flush", 32'(next_push_chan), 0);

    // R9 fill to overflow
    cfg_align = 0; cfg_sign_ext = 0; cfg_watermark = 8'd128;
    for (int i = 0; i < 140; i++) step(4'hF, 0, 0);
    chk("R9 overflow sticky", 32'(overflow), 1);
    chk("R9 level capped", 32'(fill_level), 128);

    // R12 realign a stored word
    cfg_align = 3'd7; cfg_sign_ext = 1;
    #1;
    chk("R12 realign stored", host_data, align_ref(q[0][23:0], 7, 1'b1));
    for (int k = 0; k < 8; k++) begin
      cfg_align = 3'(k); cfg_sign_ext = k[0];
      step(4'h0, 1, 0);
    end
    // R7 sign fill directed
    cfg_align = 3'd2; cfg_sign_ext = 1;
    #1;
    chk("R7 sign fill", host_data, align_ref(q[0][23:0], 2, 1'b1));

    // R10 drain and pop empty
    for (int i = 0; i < 130; i++) step(4'h0, 1, 0);
    chk("R10 empty data zero", host_data, 0);
    step(4'h0, 1, 0);
    chk("R10 empty pop ignored", 32'(fill_level), 0);
    chk("R9 overflow holds", 32'(overflow), 1);

    // random phase
    for (int blk = 0; blk < 20; blk++) begin
      cfg_chan_en   = 4'($urandom);
      cfg_watermark = 8'($urandom_range(0, 140));
      cfg_align     = 3'($urandom);
      cfg_sign_ext  = 1'($urandom);
      cfg_enable    = ($urandom_range(0, 9) != 0);
      for (int i = 0; i < 150; i++)
        step(4'($urandom), ($urandom_range(0, 3) == 0), ($urandom_range(0, 199) == 0));
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule